// File: doc/BRIEF.md
# Open-Row-First Memory Request Scheduler

This block keeps a small pool of pending memory requests and, each cycle, offers one of them to the per-bank command logic downstream. Each stored request carries a direction bit, a bank, a row and a column. An external bank tracker reports, for every bank, whether a row is open, which row that is, and whether the bank can take a command now. The scheduler uses that state to find out which stored requests would hit an open row.

In the default policy, requests that hit the open row of their bank go first, because they need only a column command. Among hits, and separately among misses, the request that arrived first wins. When `fcfs_mode` is high, row status is ignored and the oldest eligible request wins. A request whose bank reports busy is stepped over, so it never blocks requests to other banks. Age is kept in a pairwise age matrix, so no sequence counter can wrap.

A three-state controller drives the grant port. `Q_EMPTY` holds while no entry is stored. `Q_SCAN` picks a winner again every cycle. `Q_HOLD` holds an offered grant that the downstream logic has not taken yet. The transitions are:
- `Q_EMPTY` to `Q_SCAN` when a request is enqueued.
- `Q_SCAN` to `Q_HOLD` when a grant is offered and `gnt_ready` is low.
- `Q_SCAN` to `Q_EMPTY` when the last entry leaves and nothing arrives.
- `Q_HOLD` to `Q_SCAN` or `Q_EMPTY` when the held grant is accepted, depending on whether entries remain.

Top module: `frfcfs_sched`

## Requirements
- R1: After reset, `gnt_valid` is 0 and `req_ready` is 1.
- R2: With `fcfs_mode`=0, an eligible request whose row equals the open row of its bank is granted before any eligible request that misses, even an older one.
- R3: With `fcfs_mode`=0, the oldest request of the chosen class (hit or miss) is granted.
- R4: With `fcfs_mode`=1, the oldest eligible request is granted whatever its row status.
- R5: A request to a bank whose `bank_open_vld` bit is 0 is a miss, even if `bank_open_row` holds its row.
- R6: A request is eligible only while `bank_rdy[bank]` is 1. Ineligible entries are skipped and other entries can still be granted.
- R7: The grant carries the stored `write` (1 = write), bank, row and column of the chosen request without change.
- R8: With all 8 slots occupied, `req_ready` is 0 and a request presented then is not stored.
- R9: With no stored requests, `gnt_valid` is 0.
- R10: Once `gnt_valid` is 1 with `gnt_ready` 0, the next cycle shows the same grant with `gnt_valid` still 1, whatever new requests or bank state arrive.
- R11: An accepted grant frees its slot in that same clock edge, and a request may be enqueued on that edge. The enqueued request can be offered on the next cycle.
- R12: `bank_open_row` holds the row of bank b at bits [b*ROW_W +: ROW_W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fcfs_mode | input | 1 | 1 = oldest-first only, 0 = open-row hits first |
| req_valid | input | 1 | New request present |
| req_ready | output | 1 | A free slot exists |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| bank_rdy | input | NBANK | Per-bank ready to accept a command |
| bank_open_vld | input | NBANK | Per-bank row-open flag |
| bank_open_row | input | NBANK*ROW_W | Open row of each bank, packed as in R12 |
| gnt_valid | output | 1 | Grant offered |
| gnt_ready | input | 1 | Downstream takes the grant |
| gnt_write | output | 1 | Granted direction |
| gnt_bank | output | BANK_W | Granted bank |
| gnt_row | output | ROW_W | Granted row |
| gnt_col | output | COL_W | Granted column |

## Verification
The assertions assume three things about the inputs. Every bank index presented is below NBANK. Requests are counted only on a `req_valid`/`req_ready` handshake. The downstream side may hold `gnt_ready` low for any number of cycles. The bank-ready check therefore applies only to a grant offered from a fresh pick, not to one carried over in the hold state, because the tracker may drop readiness while a grant waits.

The random stimulus draws banks only in range and keeps rows in a narrow range so that hits are frequent. It changes open-row and ready state often, and throttles `gnt_ready` randomly. Directed sequences cover a full queue, an all-busy hold-off, a closed bank whose stale row matches, and an accept on the same edge as an enqueue.

// File: rtl/frfcfs_sched_pkg.sv
package frfcfs_sched_pkg;
    typedef enum logic [1:0] {
        Q_EMPTY = 2'd0,
        Q_SCAN  = 2'd1,
        Q_HOLD  = 2'd2
    } q_state_e;
endpackage

// File: rtl/frfcfs_hit_detect.sv
module frfcfs_hit_detect #(
    parameter int DEPTH  = 8,
    parameter int NBANK  = 8,
    parameter int ROW_W  = 14,
    parameter int BANK_W = 3
) (
    input  logic [DEPTH-1:0][BANK_W-1:0] ent_bank,
    input  logic [DEPTH-1:0][ROW_W-1:0]  ent_row,
    input  logic [DEPTH-1:0]             ent_vld,
    input  logic [NBANK-1:0]             bank_rdy,
    input  logic [NBANK-1:0]             bank_open_vld,
    input  logic [NBANK*ROW_W-1:0]       bank_open_row,
    output logic [DEPTH-1:0]             elig,
    output logic [DEPTH-1:0]             hit
);
    logic [NBANK-1:0][ROW_W-1:0] open_rows;
    assign open_rows = bank_open_row;

    // one comparator per entry against its own bank's row buffer
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic row_eq;
        assign row_eq  = (open_rows[ent_bank[i]] == ent_row[i]);
        assign elig[i] = ent_vld[i] && bank_rdy[ent_bank[i]];
        assign hit[i]  = bank_open_vld[ent_bank[i]] && row_eq;
    end
endmodule

// File: rtl/frfcfs_age_matrix.sv
module frfcfs_age_matrix #(
    parameter int DEPTH = 8,
    parameter int IDX_W = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        alloc_en,
    input  logic [IDX_W-1:0]            alloc_idx,
    input  logic [DEPTH-1:0]            live,
    output logic [DEPTH-1:0][DEPTH-1:0] older
);
    // older[a][b] = 1 : entry a arrived before entry b
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            older <= '0;
        end else if (alloc_en) begin
            for (int j = 0; j < DEPTH; j++) begin
                older[alloc_idx][j] <= 1'b0;
                older[j][alloc_idx] <= live[j];
            end
        end
    end
endmodule

// File: rtl/frfcfs_oldest.sv
module frfcfs_oldest #(
    parameter int DEPTH = 8,
    parameter int IDX_W = 3
) (
    input  logic [DEPTH-1:0]            mask,
    input  logic [DEPTH-1:0][DEPTH-1:0] older,
    output logic                        found,
    output logic [IDX_W-1:0]            idx
);
    logic [DEPTH-1:0] is_first;

    for (genvar i = 0; i < DEPTH; i++) begin : g_col
        logic beaten;
        always_comb begin
            beaten = 1'b0;
            for (int j = 0; j < DEPTH; j++) begin
                if (j != i && mask[j] && older[j][i]) beaten = 1'b1;
            end
            is_first[i] = mask[i] && !beaten;
        end
    end

    always_comb begin
        idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (is_first[i]) idx = IDX_W'(i);
        end
        found = |mask;
    end
endmodule

// File: rtl/frfcfs_sched.sv
module frfcfs_sched
    import frfcfs_sched_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int NBANK  = 8,
    parameter int ROW_W  = 14,
    parameter int COL_W  = 10,
    parameter int BANK_W = $clog2(NBANK)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   fcfs_mode,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_write,
    input  logic [BANK_W-1:0]      req_bank,
    input  logic [ROW_W-1:0]       req_row,
    input  logic [COL_W-1:0]       req_col,
    input  logic [NBANK-1:0]       bank_rdy,
    input  logic [NBANK-1:0]       bank_open_vld,
    input  logic [NBANK*ROW_W-1:0] bank_open_row,
    output logic                   gnt_valid,
    input  logic                   gnt_ready,
    output logic                   gnt_write,
    output logic [BANK_W-1:0]      gnt_bank,
    output logic [ROW_W-1:0]       gnt_row,
    output logic [COL_W-1:0]       gnt_col
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    // ---------------- entry storage ----------------
    logic [DEPTH-1:0]             ent_vld;
    logic [DEPTH-1:0]             ent_wr;
    logic [DEPTH-1:0][BANK_W-1:0] ent_bank;
    logic [DEPTH-1:0][ROW_W-1:0]  ent_row;
    logic [DEPTH-1:0][COL_W-1:0]  ent_col;

    q_state_e         state_q, state_d;
    logic [IDX_W-1:0] lock_idx;
    logic [IDX_W-1:0] sel_idx;
    logic             take;

    // lowest free slot
    logic             has_free;
    logic [IDX_W-1:0] free_idx;
    always_comb begin
        has_free = 1'b0;
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!ent_vld[i]) begin
                has_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    assign req_ready = has_free;

    logic alloc;
    assign alloc = req_valid && has_free;

    logic [DEPTH-1:0] take_mask, alloc_mask, vld_next;
    always_comb begin
        take_mask  = '0;
        alloc_mask = '0;
        if (take)  take_mask[sel_idx]   = 1'b1;
        if (alloc) alloc_mask[free_idx] = 1'b1;
        vld_next = (ent_vld & ~take_mask) | alloc_mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ent_vld <= '0;
        else        ent_vld <= vld_next;
    end

    always_ff @(posedge clk) begin
        if (alloc) begin
            ent_wr[free_idx]   <= req_write;
            ent_bank[free_idx] <= req_bank;
            ent_row[free_idx]  <= req_row;
            ent_col[free_idx]  <= req_col;
        end
    end

    // ---------------- age tracking ----------------
    logic [DEPTH-1:0][DEPTH-1:0] older;
    frfcfs_age_matrix #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_age (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_en  (alloc),
        .alloc_idx (free_idx),
        .live      (ent_vld & ~take_mask),
        .older     (older)
    );

    // ---------------- hit detection ----------------
    logic [DEPTH-1:0] elig, hit;
    frfcfs_hit_detect #(
        .DEPTH(DEPTH), .NBANK(NBANK), .ROW_W(ROW_W), .BANK_W(BANK_W)
    ) u_hit (
        .ent_bank      (ent_bank),
        .ent_row       (ent_row),
        .ent_vld       (ent_vld),
        .bank_rdy      (bank_rdy),
        .bank_open_vld (bank_open_vld),
        .bank_open_row (bank_open_row),
        .elig          (elig),
        .hit           (hit)
    );

    // ---------------- priority select ----------------
    logic             hit_found, any_found;
    logic [IDX_W-1:0] hit_idx, any_idx;

    frfcfs_oldest #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_old_hit (
        .mask  (elig & hit),
        .older (older),
        .found (hit_found),
        .idx   (hit_idx)
    );

    frfcfs_oldest #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_old_any (
        .mask  (elig),
        .older (older),
        .found (any_found),
        .idx   (any_idx)
    );

    logic             pick_found;
    logic [IDX_W-1:0] pick_idx;
    always_comb begin
        if (!fcfs_mode && hit_found) pick_idx = hit_idx;
        else                         pick_idx = any_idx;
        pick_found = any_found;
    end

    // ---------------- grant controller ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= Q_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                                          lock_idx <= '0;
        else if (state_q == Q_SCAN && gnt_valid && !gnt_ready) lock_idx <= sel_idx;
    end

    // outputs
    always_comb begin
        gnt_valid = 1'b0;
        sel_idx   = '0;
        unique case (state_q)
            Q_EMPTY: begin
                gnt_valid = 1'b0;
                sel_idx   = '0;
            end
            Q_SCAN: begin
                gnt_valid = pick_found;
                sel_idx   = pick_idx;
            end
            Q_HOLD: begin
                gnt_valid = 1'b1;
                sel_idx   = lock_idx;
            end
            default: begin
                gnt_valid = 1'b0;
                sel_idx   = '0;
            end
        endcase
        take      = gnt_valid && gnt_ready;
        gnt_write = ent_wr[sel_idx];
        gnt_bank  = ent_bank[sel_idx];
        gnt_row   = ent_row[sel_idx];
        gnt_col   = ent_col[sel_idx];
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            Q_EMPTY: state_d = (|vld_next) ? Q_SCAN : Q_EMPTY;
            Q_SCAN: begin
                if (gnt_valid && !gnt_ready) state_d = Q_HOLD;
                else                         state_d = (|vld_next) ? Q_SCAN : Q_EMPTY;
            end
            Q_HOLD: begin
                if (gnt_ready) state_d = (|vld_next) ? Q_SCAN : Q_EMPTY;
                else           state_d = Q_HOLD;
            end
            default: state_d = Q_EMPTY;
        endcase
    end
endmodule

// File: rtl/frfcfs_sched_chk.sv
module frfcfs_sched_chk #(
    parameter int DEPTH  = 8,
    parameter int NBANK  = 8,
    parameter int ROW_W  = 14,
    parameter int COL_W  = 10,
    parameter int BANK_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [NBANK-1:0]  bank_rdy,
    input logic              gnt_valid,
    input logic              gnt_ready,
    input logic              gnt_write,
    input logic [BANK_W-1:0] gnt_bank,
    input logic [ROW_W-1:0]  gnt_row,
    input logic [COL_W-1:0]  gnt_col
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0] occ;
    logic             held;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ  <= '0;
            held <= 1'b0;
        end else begin
            occ  <= occ + CNT_W'(req_valid && req_ready) - CNT_W'(gnt_valid && gnt_ready);
            held <= gnt_valid && !gnt_ready;
        end
    end

    // R8
    full_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == CNT_W'(DEPTH)) == !req_ready);

    // R9
    empty_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == '0) |-> !gnt_valid);

    // R10
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && !gnt_ready) |=> (gnt_valid && $stable(gnt_write) && $stable(gnt_bank)
                                       && $stable(gnt_row) && $stable(gnt_col)));

    // R6
    busy_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && !held) |-> bank_rdy[gnt_bank]);
endmodule

bind frfcfs_sched frfcfs_sched_chk #(
    .DEPTH(DEPTH), .NBANK(NBANK), .ROW_W(ROW_W), .COL_W(COL_W), .BANK_W(BANK_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .bank_rdy  (bank_rdy),
    .gnt_valid (gnt_valid),
    .gnt_ready (gnt_ready),
    .gnt_write (gnt_write),
    .gnt_bank  (gnt_bank),
    .gnt_row   (gnt_row),
    .gnt_col   (gnt_col)
);

// File: tb/frfcfs_sched_bench.sv
module frfcfs_sched_bench;
    localparam int DEPTH = 8, NBANK = 8, ROW_W = 14, COL_W = 10, BANK_W = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    always #10 clk = ~clk;

    logic                   fcfs_mode = 1'b0;
    logic                   req_valid = 1'b0, req_write = 1'b0;
    logic [BANK_W-1:0]      req_bank = '0;
    logic [ROW_W-1:0]       req_row = '0;
    logic [COL_W-1:0]       req_col = '0;
    logic [NBANK-1:0]       bank_rdy = '0, bank_open_vld = '0;
    logic [ROW_W-1:0]       orow [NBANK];
    logic [NBANK*ROW_W-1:0] bank_open_row;
    logic                   gnt_ready = 1'b0;
    logic                   req_ready, gnt_valid, gnt_write;
    logic [BANK_W-1:0]      gnt_bank;
    logic [ROW_W-1:0]       gnt_row;
    logic [COL_W-1:0]       gnt_col;

    // R12 packing of per-bank open rows
    always_comb for (int b = 0; b < NBANK; b++) bank_open_row[b*ROW_W +: ROW_W] = orow[b];

    frfcfs_sched u_frfcfs_sched (
        .clk(clk), .rst_n(rst_n), .fcfs_mode(fcfs_mode),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .bank_rdy(bank_rdy), .bank_open_vld(bank_open_vld), .bank_open_row(bank_open_row),
        .gnt_valid(gnt_valid), .gnt_ready(gnt_ready), .gnt_write(gnt_write),
        .gnt_bank(gnt_bank), .gnt_row(gnt_row), .gnt_col(gnt_col)
    );

    int checks = 0, errors = 0;
    bit done = 0;

    // reference queue
    bit              m_v [DEPTH];
    bit              m_w [DEPTH];
    int              m_b [DEPTH];
    int              m_r [DEPTH];
    int              m_c [DEPTH];
    int              m_seq [DEPTH];
    int              seq_ctr = 0;
    int              lock = -1;

    logic            obs_valid, obs_ready, obs_write;
    int              obs_bank, obs_row, obs_col;

    task automatic check(string tag, bit ok, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int model_count();
        int n = 0;
        for (int i = 0; i < DEPTH; i++) if (m_v[i]) n++;
        return n;
    endfunction

    function automatic bit model_hit(int i);
        return bank_open_vld[m_b[i]] && (int'(orow[m_b[i]]) == m_r[i]);
    endfunction

    function automatic int model_pick();
        int bh = -1, ba = -1;
        if (lock >= 0) return lock;
        for (int i = 0; i < DEPTH; i++) begin
            if (m_v[i] && bank_rdy[m_b[i]]) begin
                if (ba < 0 || m_seq[i] < m_seq[ba]) ba = i;
                if (model_hit(i) && (bh < 0 || m_seq[i] < m_seq[bh])) bh = i;
            end
        end
        if (!fcfs_mode && bh >= 0) return bh;
        return ba;
    endfunction

    task automatic tick();
        int  p;
        bit  exp_ready, acc_g, acc_e;
        string tag;
        @(negedge clk);
        p = model_pick();
        exp_ready = model_count() < DEPTH;
        obs_valid = gnt_valid; obs_ready = req_ready; obs_write = gnt_write;
        obs_bank = int'(gnt_bank); obs_row = int'(gnt_row); obs_col = int'(gnt_col);
        check("R8 req_ready", req_ready == exp_ready, int'(req_ready), int'(exp_ready));
        if (p < 0) tag = (model_count() == 0) ? "R9 gnt_valid" : "R6 gnt_valid";
        else if (lock >= 0) tag = "R10 gnt_valid";
        else if (fcfs_mode) tag = "R4 gnt_valid";
        else tag = model_hit(p) ? "R2 gnt_valid" : "R3 gnt_valid";
        check(tag, gnt_valid == (p >= 0), int'(gnt_valid), int'(p >= 0));
        if (p >= 0 && gnt_valid) begin
            check("R7 fields", gnt_write == m_w[p] && obs_bank == m_b[p] && obs_row == m_r[p]
                  && obs_col == m_c[p], obs_row * 1024 + obs_col, m_r[p] * 1024 + m_c[p]);
        end
        acc_g = (p >= 0) && gnt_ready;
        acc_e = req_valid && exp_ready;
        @(posedge clk);
        #1;
        if (p >= 0 && !gnt_ready) lock = p;
        else lock = -1;
        if (acc_g) m_v[p] = 0;
        if (acc_e) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (!m_v[i]) begin
                    m_v[i] = 1; m_w[i] = req_write; m_b[i] = int'(req_bank);
                    m_r[i] = int'(req_row); m_c[i] = int'(req_col); m_seq[i] = seq_ctr++;
                    break;
                end
            end
        end
    endtask

    task automatic push(int b, int r, int c, bit w);
        req_valid = 1; req_bank = BANK_W'(b); req_row = ROW_W'(r); req_col = COL_W'(c); req_write = w;
        tick();
        req_valid = 0;
    endtask

    task automatic drain();
        bank_rdy = '1; gnt_ready = 1;
        for (int k = 0; k < 12; k++) tick();
    endtask

    initial begin
        for (int b = 0; b < NBANK; b++) orow[b] = '0;
        void'($urandom(32'd2718));
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        tick();
        check("R1 gnt_valid after reset", obs_valid == 0, int'(obs_valid), 0);
        check("R1 req_ready after reset", obs_ready == 1, int'(obs_ready), 1);

        // R8: fill with everything held off, ninth request dropped
        bank_rdy = '0; gnt_ready = 0;
        for (int k = 0; k < 9; k++) push(k % 8, k, k, k[0]);
        tick();
        check("R8 full ready low", obs_ready == 0, int'(obs_ready), 0);
        drain();
        check("R9 empty after drain", obs_valid == 0, int'(obs_valid), 0);

        // R5: closed bank with matching stale row is a miss
        bank_rdy = '0; bank_open_vld = 8'b0000_1000; orow[3] = 7; orow[2] = 1;
        push(3, 5, 11, 0);
        push(2, 1, 12, 1);
        bank_rdy = '1; gnt_ready = 1;
        tick();
        check("R5 closed bank not a hit", obs_bank == 3, obs_bank, 3);
        drain();

        // R2 and R4: younger hit versus older miss
        bank_rdy = '0; bank_open_vld = 8'b0000_0010; orow[1] = 3;
        push(1, 2, 21, 0);
        push(1, 3, 22, 1);
        bank_rdy = '1; gnt_ready = 1;
        tick();
        check("R2 hit first", obs_row == 3, obs_row, 3);
        drain();
        fcfs_mode = 1; bank_rdy = '0;
        push(1, 2, 31, 0);
        push(1, 3, 32, 1);
        bank_rdy = '1; gnt_ready = 1;
        tick();
        check("R4 oldest first", obs_row == 2, obs_row, 2);
        drain();
        fcfs_mode = 0;

        // R6: busy bank skipped
        bank_rdy = '0;
        push(1, 9, 41, 0);
        push(5, 9, 42, 0);
        bank_rdy = 8'b0010_0000; gnt_ready = 1;
        tick();
        check("R6 busy bank skipped", obs_bank == 5, obs_bank, 5);
        drain();

        // R11: accept and enqueue on one edge
        bank_rdy = '1; gnt_ready = 0;
        push(4, 6, 51, 0);
        gnt_ready = 1;
        push(6, 8, 52, 1);
        tick();
        check("R11 refill granted", obs_valid == 1 && obs_row == 8, obs_row, 8);
        drain();

        // random phase
        for (int cyc = 0; cyc < 4000; cyc++) begin
            if (cyc % 700 == 0) fcfs_mode = ~fcfs_mode;
            req_valid = ($urandom % 10) < 6;
            req_write = $urandom % 2;
            req_bank  = BANK_W'($urandom % NBANK);
            req_row   = ROW_W'($urandom % 4);
            req_col   = COL_W'($urandom);
            for (int b = 0; b < NBANK; b++) begin
                bank_rdy[b] = ($urandom % 4) != 0;
                if (($urandom % 10) == 0) begin
                    bank_open_vld[b] = $urandom % 4 != 0;
                    orow[b] = ROW_W'($urandom % 4);
                end
            end
            gnt_ready = ($urandom % 10) < 7;
            tick();
        end
        req_valid = 0;
        drain();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule